// File: doc/BRIEF.md
# Parallel Printer Port with Acknowledge Latch

This block is the host side of a byte-wide parallel printer link. It has two host registers, chosen by a single select bit. A write to the data register puts the byte on the printer data lines at the next clock edge. It then starts an active-low strobe sequence: a setup gap, a strobe pulse and a hold gap, each a parameterised number of clocks. The byte stays on the lines until the next data write. The block does not check whether the printer is ready. The driver reads the status register and decides for itself.

The status register reports four things. Bit 0 is a ready flag: a data write clears it, and a synchronized falling edge of the printer's active-low acknowledge sets it again. Bits 1 to 3 show the synchronized busy, paper-end and select lines. A write to the status select drives the printer's active-low fault output from bit 0. All printer inputs pass through two-flop synchronizers.

Top module: `prn_port`

## Requirements
- R1: A host write with `reg_sel`=0 puts `wr_data` on `prn_data` after that clock edge. The ready flag does not gate this, so a write while the flag is 0 is still sent.
- R2: A data write (`reg_sel`=0) clears status bit 0 after that edge.
- R3: A high-to-low transition of `prn_ack_n` sets status bit 0 on the third rising edge after the low level is first sampled. A level held low sets nothing a second time. If a data write and the detected fall arrive in the same cycle, the write wins and the flag stays 0.
- R4: Status bits 1, 2 and 3 report `prn_busy`, `prn_paper_end` and `prn_select`, two clock edges after each input changes. Status bits 7 to 4 always read 0.
- R5: A host write with `reg_sel`=1 sets `prn_fault_n` to the inverse of `wr_data[0]` (1 drives fault low). The other data bits have no effect.
- R6: After a data write edge, `prn_strobe_n` stays high for `SETUP_CLKS` cycles, then is low for exactly `STROBE_CLKS` cycles. It then stays high for `HOLD_CLKS` cycles before the port is idle, and makes no further pulse.
- R7: `prn_data` changes only on a data write.
- R8: After reset: status bit 0 = 1, `prn_strobe_n` = 1, `prn_fault_n` = 1, `prn_data` = 0.
- R9: A data write during a strobe sequence loads the new byte, forces the strobe high at once and restarts the sequence from its setup phase.
- R10: `rd_data` is combinational on `reg_sel`. It returns the last data byte for `reg_sel`=0 and the status byte for `reg_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 data, 1 status/control |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data for the selected register |
| prn_data | output | 8 | Printer data lines |
| prn_strobe_n | output | 1 | Active-low data strobe to printer |
| prn_ack_n | input | 1 | Active-low acknowledge from printer |
| prn_busy | input | 1 | Printer busy |
| prn_paper_end | input | 1 | Printer paper end |
| prn_select | input | 1 | Printer selected/online |
| prn_fault_n | output | 1 | Active-low fault line to printer |

## Verification
A ready latch in the wrong state shows up on the next status read. It either blocks a driver that is waiting for it or lets the driver overrun the printer. The bench therefore places acknowledge falls exactly one edge before, at, and after the cycle in which they become visible, including a fall that collides with a write. A sequencer counter that is off by one shows up within a few cycles as a strobe that starts early or has the wrong width. The bench samples the strobe on every cycle after each write, including a write that interrupts a pulse. Synchronizer depth shows up as status bits that change one edge early or late.

// File: rtl/prn_port.sv
module prn_port #(
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 4,
  parameter int HOLD_CLKS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] prn_data,
  output logic       prn_strobe_n,
  input  logic       prn_ack_n,
  input  logic       prn_busy,
  input  logic       prn_paper_end,
  input  logic       prn_select,
  output logic       prn_fault_n
);

  localparam int MAXC = (SETUP_CLKS > STROBE_CLKS) ?
                        ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                        ((STROBE_CLKS > HOLD_CLKS) ? STROBE_CLKS : HOLD_CLKS);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] SETUP_LD  = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] STROBE_LD = CW'(STROBE_CLKS - 1);
  localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CLKS - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [2:0]    ack_q;
  logic [1:0]    busy_q, pend_q, sel_q;
  logic          ready;
  logic [7:0]    status;

  wire data_wr  = wr_en & ~reg_sel;
  wire ctrl_wr  = wr_en &  reg_sel;
  wire ack_fall = ack_q[2] & ~ack_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 3'b111;
      busy_q <= '0;
      pend_q <= '0;
      sel_q  <= '0;
    end else begin
      ack_q  <= {ack_q[1:0], prn_ack_n};
      busy_q <= {busy_q[0], prn_busy};
      pend_q <= {pend_q[0], prn_paper_end};
      sel_q  <= {sel_q[0], prn_select};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prn_data    <= '0;
      prn_fault_n <= 1'b1;
      ready       <= 1'b1;
    end else begin
      if (data_wr) prn_data <= wr_data;
      if (ctrl_wr) prn_fault_n <= ~wr_data[0];
      if (data_wr) ready <= 1'b0;
      else if (ack_fall) ready <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (data_wr) begin
      phase <= PH_SETUP;
      cnt   <= SETUP_LD;
    end else if (phase != PH_IDLE) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        unique case (phase)
          PH_SETUP: begin phase <= PH_PULSE; cnt <= STROBE_LD; end
          PH_PULSE: begin phase <= PH_HOLD;  cnt <= HOLD_LD;   end
          default:  begin phase <= PH_IDLE;  cnt <= '0;        end
        endcase
      end
    end
  end

  assign prn_strobe_n = (phase != PH_PULSE);
  assign status  = {4'b0000, sel_q[1], pend_q[1], busy_q[1], ready};
  assign rd_data = reg_sel ? status : prn_data;

endmodule

// File: rtl/prn_port_chk.sv
module prn_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] prn_data,
  input logic       prn_strobe_n,
  input logic       prn_ack_n,
  input logic       prn_busy,
  input logic       prn_fault_n,
  input logic       ready,
  input logic [7:0] status
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  p_data_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> prn_data == $past(wr_data));

  p_wr_clears_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> !ready);

  p_ready_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $rose(ready)) |-> !$past(prn_ack_n, 2));

  p_busy_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> status[1] == $past(prn_busy, 2));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'h0);

  p_fault_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> prn_fault_n == !$past(wr_data[0]));

  p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !reg_sel) |=> $stable(prn_data));

  p_restart_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> prn_strobe_n);

endmodule

bind prn_port prn_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
  .wr_data(wr_data), .prn_data(prn_data), .prn_strobe_n(prn_strobe_n),
  .prn_ack_n(prn_ack_n), .prn_busy(prn_busy), .prn_fault_n(prn_fault_n),
  .ready(ready), .status(status)
);

// File: tb/sim_prn_port.sv
`timescale 1ns/1ps
module sim_prn_port;
  localparam int S = 2, P = 4, H = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, prn_data;
  logic prn_strobe_n, prn_fault_n;
  logic prn_ack_n = 1'b1, prn_busy = 1'b0, prn_paper_end = 1'b0, prn_select = 1'b0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  prn_port #(.SETUP_CLKS(S), .STROBE_CLKS(P), .HOLD_CLKS(H)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .prn_data(prn_data),
    .prn_strobe_n(prn_strobe_n), .prn_ack_n(prn_ack_n), .prn_busy(prn_busy),
    .prn_paper_end(prn_paper_end), .prn_select(prn_select),
    .prn_fault_n(prn_fault_n));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic sel, logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic status_rd(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b1; #0.5;
    v = rd_data;
  endtask

  task automatic pulse_ack();
    @(negedge clk); prn_ack_n = 1'b0;
    repeat (3) @(negedge clk);
    prn_ack_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure_strobe(string req, logic [7:0] d);
    int first = 0, lows = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (!prn_strobe_n) begin
        lows++;
        if (first == 0) first = i;
      end
      if (prn_data !== d) begin
        checks++; errors++;
        $display("FAIL R7: actual %0h expected %0h", prn_data, d);
      end
    end
    check({req, " start"}, first, S + 1);
    check({req, " width"}, lows, P);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    status_rd(v);
    check("R8 ready", v[0], 1);
    check("R8 strobe", prn_strobe_n, 1);
    check("R8 fault", prn_fault_n, 1);
    check("R8 data", prn_data, 0);
  endtask

  task automatic t_write_strobe();
    logic [7:0] v;
    host_wr(1'b0, 8'hA5);
    check("R1 data", prn_data, 8'hA5);
    measure_strobe("R6", 8'hA5);
    status_rd(v);
    check("R2 ready cleared", v[0], 0);
    @(negedge clk); reg_sel = 1'b0; #0.5;
    check("R10 data readback", rd_data, 8'hA5);
    host_wr(1'b0, 8'h3C);
    check("R1 send while not ready", prn_data, 8'h3C);
    measure_strobe("R6 second", 8'h3C);
  endtask

  task automatic t_ack_timing();
    logic [7:0] v;
    @(negedge clk); prn_ack_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_sel = 1'b1; #0.5;
    check("R3 not yet set", rd_data[0], 0);
    @(negedge clk); #0.5;
    check("R3 set on third edge", rd_data[0], 1);
    host_wr(1'b0, 8'h11);
    repeat (6) @(negedge clk);
    status_rd(v);
    check("R3 held low no re-set", v[0], 0);
    prn_ack_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse_ack();
    status_rd(v);
    check("R3 set after new fall", v[0], 1);
  endtask

  task automatic t_ack_collision();
    logic [7:0] v;
    host_wr(1'b0, 8'h22);
    repeat (3) @(negedge clk);
    prn_ack_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b0; wr_data = 8'h23; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    status_rd(v);
    check("R3 write wins over fall", v[0], 0);
    prn_ack_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_status_inputs();
    logic [7:0] v;
    @(negedge clk);
    prn_busy = 1'b1; prn_paper_end = 1'b0; prn_select = 1'b1; reg_sel = 1'b1;
    @(posedge clk); @(negedge clk); #0.5;
    check("R4 one edge late", rd_data[3:1], 3'b000);
    @(negedge clk); #0.5;
    check("R4 busy/select", rd_data[3:1], 3'b101);
    check("R4 upper zero", rd_data[7:4], 0);
    prn_busy = 1'b0; prn_paper_end = 1'b1; prn_select = 1'b0;
    repeat (3) @(negedge clk);
    status_rd(v);
    check("R4 paper end", v[3:1], 3'b010);
    check("R4 upper zero 2", v[7:4], 0);
  endtask

  task automatic t_fault();
    host_wr(1'b1, 8'h01);
    check("R5 fault asserted", prn_fault_n, 0);
    host_wr(1'b1, 8'hFE);
    check("R5 other bits ignored", prn_fault_n, 1);
    check("R7 data untouched by ctrl", prn_data, 8'h23);
  endtask

  task automatic t_restart();
    host_wr(1'b0, 8'h5A);
    repeat (S + 1) @(negedge clk);
    check("R9 pulse running", prn_strobe_n, 0);
    wr_data = 8'h6B; reg_sel = 1'b0; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
    check("R9 strobe forced high", prn_strobe_n, 1);
    check("R9 new data", prn_data, 8'h6B);
    measure_strobe("R9 restart", 8'h6B);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write_strobe();
        t_ack_timing();
        t_ack_collision();
        t_status_inputs();
        t_fault();
        t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule